// File: doc/BRIEF.md
# Video Control Register and Palette Access Arbiter

This block sits between a CPU's 8-bit I/O space and a tile-and-sprite video pipeline. The CPU writes a control byte that carries two live bits. One asks for ownership of the palette RAM. The other turns the character (tile) layer on or off. The CPU can also read a status byte that reports the current vertical blanking state and whether the palette has been handed over.

The palette is never handed to the CPU in the middle of a frame. After the CPU raises its request, the grant is given at the first clock on which vertical blanking is seen to begin. The CPU polls the status byte until the grant flag reads 1, writes the palette, and then clears its request to give the RAM back to the video side. The screen output is forced dark for as long as the request is held, so a palette update never shows as a glitch on the display. While the grant is absent, palette write strobes from the CPU are dropped.

Top module: `vidctl_palette_arb`

## Requirements
- R1: After reset the control register holds 0x00. No palette request is active, the character layer is disabled, `blank_out` is 0, `pal_cpu_sel` is 0, and `tile_pix_out` is 0.
- R2: A write to the control address (default 0x00) loads the control register on that clock edge. `blank_out` equals control bit 3 (the palette request) from the following cycle onward.
- R3: The grant rises only at a clock edge where the request is held, `vblank_in` is 1, and `vblank_in` was 0 at the previous edge. A request raised while vblank is already high waits for the next vblank start.
- R4: Status bit 0 always equals the current `vblank_in`.
- R5: Once granted, the grant holds until the request is cleared. It drops at the clock edge after the edge that cleared the request.
- R6: `pal_we_out` equals `pal_cpu_we_in` while the grant is held and is 0 otherwise.
- R7: Control bit 6 enables the character layer. When it is 1, `tile_pix_out` equals `tile_pix_in`. When it is 0, `tile_pix_out` is 0.
- R8: When the status address (default 0x05) is selected, bits 7..4 and 2..1 read 0. Any address other than the status address reads 0x00.
- R9: Writes to addresses other than the control address leave the control register unchanged.
- R10: Status bit 3 and `pal_cpu_sel` both equal the grant. `pal_cpu_sel` = 1 means the palette RAM is owned by the CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | CPU I/O port address |
| io_wr | input | 1 | CPU write strobe, one cycle per write |
| io_wdata | input | 8 | CPU write data |
| io_rdata | output | 8 | Read data for the address on `io_addr` (combinational) |
| vblank_in | input | 1 | Vertical blanking from video timing |
| pal_cpu_we_in | input | 1 | CPU palette write strobe |
| pal_cpu_sel | output | 1 | Palette RAM owner: 1 = CPU, 0 = video pipeline |
| pal_we_out | output | 1 | Gated palette write strobe to the RAM |
| tile_pix_in | input | PIX_W | Tile-layer pixel from the pipeline |
| tile_pix_out | output | PIX_W | Tile-layer pixel after the layer enable |
| blank_out | output | 1 | Forces the screen dark while a palette request is held |

## Verification
The assertions check the following on every cycle:
- The status read bits match `vblank_in` and the grant.
- The unused status bits read 0.
- A palette write never passes without the grant.
- The grant never stands without the request having been held at the edge before.
- A grant only rises from an edge that saw vblank high.
- `blank_out` tracks the bit most recently written.

The bench scenarios are needed for the behaviour that depends on history:
- The grant waits out a request raised partway through vblank.
- The grant lags the release by exactly one cycle.
- Writes to other addresses leave the layer enable and request untouched.

// File: rtl/vidctl_pkg.sv
// Package: shared bit positions and the decoded control type for the
// video control block. Assumes an 8-bit CPU data bus.
package vidctl_pkg;
    localparam int DATA_W         = 8;
    localparam int CTRL_REQ_BIT   = 3;   // palette request
    localparam int CTRL_LAYER_BIT = 6;   // character layer enable
    localparam int STAT_VBL_BIT   = 0;   // live vblank
    localparam int STAT_GNT_BIT   = 3;   // palette granted

    typedef struct packed {
        logic layer_en;
        logic pal_req;
    } vidctl_cfg_t;
endpackage

// File: rtl/vidctl_ctrl_reg.sv
// Control register: decodes CPU writes to the control address and keeps
// the two live control bits. Assumes io_wr lasts one cycle per write.
module vidctl_ctrl_reg
    import vidctl_pkg::*;
#(
    parameter int                 ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output vidctl_cfg_t       cfg
);
    logic hit;
    logic unused_wdata;

    // Address match for a control write.
    assign hit = io_wr && (io_addr == CTRL_ADDR);
    assign unused_wdata = ^io_wdata;

    // Load the live bits on a control write; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (hit) begin
            cfg.pal_req  <= io_wdata[CTRL_REQ_BIT];
            cfg.layer_en <= io_wdata[CTRL_LAYER_BIT];
        end
    end
endmodule

// File: rtl/vidctl_pal_arb.sv
// Palette arbiter: hands palette RAM to the CPU at the first edge where
// vblank starts while a request is held. It keeps the grant until the
// request drops and gates CPU write strobes with the grant.
// Assumes vblank_in is synchronous to clk.
module vidctl_pal_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic pal_req,
    input  logic vblank_in,
    input  logic cpu_we_in,
    output logic grant,
    output logic pal_we_out
);
    logic vblank_q;
    logic vblank_start;

    // Remember last cycle's vblank so that its rising edge can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) vblank_q <= 1'b0;
        else        vblank_q <= vblank_in;
    end

    assign vblank_start = vblank_in && !vblank_q;

    // Grant at vblank start while requested; release once the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n)            grant <= 1'b0;
        else if (!pal_req)     grant <= 1'b0;
        else if (vblank_start) grant <= 1'b1;
    end

    // Pass CPU palette writes only while granted.
    assign pal_we_out = cpu_we_in && grant;
endmodule

// File: rtl/vidctl_status.sv
// Status read mux: builds the status byte from live vblank and the grant.
// Any other address reads zero. The read is combinational.
module vidctl_status
    import vidctl_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(5)
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              vblank,
    input  logic              grant,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] stat_byte;

    // One generate branch per status bit: a live flag or a constant zero.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == STAT_VBL_BIT) begin : g_vbl
            assign stat_byte[b] = vblank;
        end else if (b == STAT_GNT_BIT) begin : g_gnt
            assign stat_byte[b] = grant;
        end else begin : g_zero
            assign stat_byte[b] = 1'b0;
        end
    end

    // Select the status byte only at the status address.
    assign rdata = (io_addr == STAT_ADDR) ? stat_byte : '0;
endmodule

// File: rtl/vidctl_pixel_gate.sv
// Pixel gate: suppresses tile-layer pixels when the layer is disabled and
// drives the screen blank while a palette request is held.
module vidctl_pixel_gate #(
    parameter int PIX_W = 8
) (
    input  logic             layer_en,
    input  logic             pal_req,
    input  logic [PIX_W-1:0] tile_pix_in,
    output logic [PIX_W-1:0] tile_pix_out,
    output logic             blank_out
);
    // Zero the tile pixel unless the layer is enabled.
    assign tile_pix_out = layer_en ? tile_pix_in : '0;
    // Blank for the whole time the CPU holds a palette request.
    assign blank_out    = pal_req;
endmodule

// File: rtl/vidctl_palette_arb.sv
// Top level: video control register, status port and palette arbiter.
// The CPU writes the control address, polls the status address for the
// grant, and then writes the palette. Reset is synchronous and active-low.
module vidctl_palette_arb
    import vidctl_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                PIX_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(5)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              vblank_in,
    input  logic              pal_cpu_we_in,
    output logic              pal_cpu_sel,
    output logic              pal_we_out,
    input  logic [PIX_W-1:0]  tile_pix_in,
    output logic [PIX_W-1:0]  tile_pix_out,
    output logic              blank_out
);
    vidctl_cfg_t cfg;
    logic        grant;

    vidctl_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .cfg(cfg)
    );

    vidctl_pal_arb u_arb (
        .clk(clk), .rst_n(rst_n), .pal_req(cfg.pal_req),
        .vblank_in(vblank_in), .cpu_we_in(pal_cpu_we_in),
        .grant(grant), .pal_we_out(pal_we_out)
    );

    vidctl_status #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_stat (
        .io_addr(io_addr), .vblank(vblank_in), .grant(grant), .rdata(io_rdata)
    );

    vidctl_pixel_gate #(.PIX_W(PIX_W)) u_pix (
        .layer_en(cfg.layer_en), .pal_req(cfg.pal_req),
        .tile_pix_in(tile_pix_in), .tile_pix_out(tile_pix_out),
        .blank_out(blank_out)
    );

    // Palette RAM is owned by the CPU exactly while granted.
    assign pal_cpu_sel = grant;
endmodule

// File: rtl/vidctl_palette_arb_chk.sv
// Checker: port-level properties of the video control block. It is bound
// to every instance of the top module.
module vidctl_palette_arb_chk #(
    parameter int                ADDR_W    = 8,
    parameter int                PIX_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(5)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              vblank_in,
    input logic              pal_cpu_we_in,
    input logic              pal_cpu_sel,
    input logic              pal_we_out,
    input logic [PIX_W-1:0]  tile_pix_in,
    input logic [PIX_W-1:0]  tile_pix_out,
    input logic              blank_out
);
    p_blank_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == CTRL_ADDR) |=> (blank_out == $past(io_wdata[3])));

    p_grant_at_vblank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pal_cpu_sel) |-> $past(vblank_in));

    p_status_vblank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == STAT_ADDR) |-> (io_rdata[0] == vblank_in));

    p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pal_cpu_sel |-> $past(blank_out));

    p_we_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pal_cpu_sel |-> !pal_we_out);

    p_layer_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_pix_out != '0) |-> (tile_pix_out == tile_pix_in));

    p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == STAT_ADDR) |-> ((io_rdata & 8'hF6) == 8'h00));

    p_status_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == STAT_ADDR) |-> (io_rdata[3] == pal_cpu_sel));
endmodule

bind vidctl_palette_arb vidctl_palette_arb_chk #(
    .ADDR_W(ADDR_W), .PIX_W(PIX_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .vblank_in(vblank_in),
    .pal_cpu_we_in(pal_cpu_we_in), .pal_cpu_sel(pal_cpu_sel),
    .pal_we_out(pal_we_out), .tile_pix_in(tile_pix_in),
    .tile_pix_out(tile_pix_out), .blank_out(blank_out)
);

// File: tb/vidctl_palette_arb_bench.sv
// Directed bench: one task per scenario, each checking its own results.
// Inputs change on the falling edge; outputs are sampled there too.
module vidctl_palette_arb_bench;
    localparam logic [7:0] CTRL = 8'h00;
    localparam logic [7:0] STAT = 8'h05;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = '0;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       vblank_in = 1'b0;
    logic       pal_cpu_we_in = 1'b0;
    logic       pal_cpu_sel, pal_we_out, blank_out;
    logic [7:0] tile_pix_in = 8'hA5;
    logic [7:0] tile_pix_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vidctl_palette_arb u_vidctl_palette_arb (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .vblank_in(vblank_in),
        .pal_cpu_we_in(pal_cpu_we_in), .pal_cpu_sel(pal_cpu_sel),
        .pal_we_out(pal_we_out), .tile_pix_in(tile_pix_in),
        .tile_pix_out(tile_pix_out), .blank_out(blank_out)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        tick();
        io_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        io_addr = a;
        #0.5;
        d = io_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(STAT, d);
        check("R1 status", d, 8'h00);
        check("R1 blank", 8'(blank_out), 8'h0);
        check("R1 sel", 8'(pal_cpu_sel), 8'h0);
        check("R1 tile", tile_pix_out, 8'h00);
    endtask

    task automatic t_layer();
        wr(CTRL, 8'h40);
        check("R7 layer on", tile_pix_out, 8'hA5);
        tile_pix_in = 8'h3C; #0.5;
        check("R7 layer follow", tile_pix_out, 8'h3C);
        wr(8'h03, 8'h00);
        check("R9 other addr keeps layer", tile_pix_out, 8'h3C);
        wr(CTRL, 8'h00);
        check("R7 layer off", tile_pix_out, 8'h00);
        wr(8'h05, 8'h48);
        check("R9 other addr no req", 8'(blank_out), 8'h0);
        check("R9 other addr no layer", tile_pix_out, 8'h00);
    endtask

    task automatic t_grant();
        logic [7:0] d;
        pal_cpu_we_in = 1'b1;
        wr(CTRL, 8'h08);
        check("R2 blank on req", 8'(blank_out), 8'h1);
        tick(3);
        rd(STAT, d);
        check("R3 no grant before vblank", d, 8'h00);
        check("R6 we blocked", 8'(pal_we_out), 8'h0);
        vblank_in = 1'b1;
        rd(STAT, d);
        check("R4 vblank live", d, 8'h01);
        tick();
        rd(STAT, d);
        check("R3 grant at vblank start", d, 8'h09);
        check("R10 sel", 8'(pal_cpu_sel), 8'h1);
        check("R6 we passes", 8'(pal_we_out), 8'h1);
        pal_cpu_we_in = 1'b0; #0.5;
        check("R6 we follows", 8'(pal_we_out), 8'h0);
        vblank_in = 1'b0;
        tick(2);
        check("R5 grant held past vblank", 8'(pal_cpu_sel), 8'h1);
        vblank_in = 1'b1;
        tick();
        wr(CTRL, 8'h00);
        check("R2 blank off", 8'(blank_out), 8'h0);
        check("R5 grant lags release", 8'(pal_cpu_sel), 8'h1);
        tick();
        check("R5 grant dropped", 8'(pal_cpu_sel), 8'h0);
    endtask

    task automatic t_mid_vblank();
        logic [7:0] d;
        wr(CTRL, 8'h48);
        tick(3);
        check("R3 mid-vblank request waits", 8'(pal_cpu_sel), 8'h0);
        vblank_in = 1'b0;
        tick();
        check("R3 still waiting", 8'(pal_cpu_sel), 8'h0);
        vblank_in = 1'b1;
        tick();
        check("R3 grant at next vblank", 8'(pal_cpu_sel), 8'h1);
        check("R7 layer kept with req", tile_pix_out, 8'h3C);
        rd(8'h01, d);
        check("R8 other addr reads 0", d, 8'h00);
        rd(STAT, d);
        check("R8 unused bits zero", d & 8'hF6, 8'h00);
        wr(CTRL, 8'h00);
        tick();
        vblank_in = 1'b0;
        rd(STAT, d);
        check("R4 vblank low", d, 8'h00);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_layer();
        t_grant();
        t_mid_vblank();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule